// File: doc/BRIEF.md
# SPI Serial Flash Command Engine

This block is the device side of a single-bit SPI flash memory. It oversamples the chip-select, serial-clock and serial-input pins with the system clock, decodes a small command set and serves a byte-wide storage array held in on-chip registers. The array depth is a parameter (a power of two). The command address is 24 bits wide, and only its low log2(depth) bits select a byte.

Four opcodes are decoded. A fast read takes an address and one ignored dummy byte, then streams bytes for as long as the device stays selected. A byte program takes an address and one data byte and is committed only when chip select is released on a byte boundary. A write-enable command arms a latch that a program needs. A status read returns the busy flag and the latch. A program that is accepted holds the busy flag for a parameterized number of cycles, which stands in for the self-timed write. Programs into a parameterized protected index range are dropped. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work: input is sampled on rising SCK and output changes after falling SCK.

Top module: `spif_engine`

## Requirements
- R1: Opcode 0x0B, then a 24-bit address MSB first, then 8 dummy clocks whose input value has no effect, starts a read. Data bytes follow MSB first. Each bit changes after a falling SCK edge and is valid at the next rising edge.
- R2: During a read the byte index increments after each byte, and output continues for as long as cs_n stays low.
- R3: After the byte at index MEM_DEPTH-1 the next byte comes from index 0. Address bits at or above log2(MEM_DEPTH) do not select a byte.
- R4: Opcode 0x02, then a 24-bit address and one data byte, all MSB first, is a program. It takes effect only when cs_n rises after the data byte is complete.
- R5: A program is ignored unless the write-enable latch is set.
- R6: An accepted program sets the busy flag for exactly PROG_CYCLES clock cycles.
- R7: A program stores the old byte ANDed with the data byte, so bits can only go from 1 to 0.
- R8: A program to an index in PROT_LO..PROT_HI (inclusive, default 0xF0..0xFF) is ignored. It leaves the array, the busy flag and the write-enable latch unchanged.
- R9: so_oe is low while the opcode, address and dummy bytes are input and while cs_n is high. It is high while read or status data is output.
- R10: Opcode 0x05 returns a status byte with busy in bit 0, the write-enable latch in bit 1 and zeros in bits 7..2. The byte repeats while cs_n stays low.
- R11: Opcode 0x06, completed on a byte boundary, sets the write-enable latch. The latch clears when a program's busy period ends.
- R12: If cs_n rises with a partial byte received, the command is aborted: no program and no write-enable take effect.
- R13: Reads give the same data in SPI mode 0 and in SPI mode 3.
- R14: After reset every array byte is 0xFF, and the busy flag and the write-enable latch are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data into the device |
| so | output | 1 | SPI serial data out of the device |
| so_oe | output | 1 | Output enable for so; low means the pad is high impedance |

## Verification
Each SPI pin passes through SYNC_STAGES flops and one edge-detect register. A data bit therefore reaches so about SYNC_STAGES+1 system cycles after its falling SCK edge, and a program commits about SYNC_STAGES+1 cycles after cs_n rises. The busy flag then stays high for PROG_CYCLES cycles. The bench holds each SCK phase for eight system cycles and samples so and so_oe at the end of the low phase, just before the rising edge. After raising cs_n it waits eight cycles before the next command. It observes busy and the latch only through status reads, timed well inside or well past the busy window, and reads the array back through fast reads.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [7:0] OPC_READ = 8'h0B;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_STAT = 8'h05;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_WDATA, PH_STREAM, PH_DONE, PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_PROG, CMD_WREN, CMD_STAT
  } kind_e;
endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  output logic rst_sync_n,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_done,
  output logic si_s
);
  logic [STAGES-1:0] cs_sh, sck_sh, si_sh;
  logic [1:0] rst_sh;
  logic sck_d, sel_d, sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh <= '0;
      cs_sh  <= '1;
      sck_sh <= '0;
      si_sh  <= '0;
      sck_d  <= 1'b0;
      sel_d  <= 1'b0;
    end else begin
      rst_sh <= {rst_sh[0], 1'b1};
      cs_sh  <= {cs_sh[STAGES-2:0], cs_n_i};
      sck_sh <= {sck_sh[STAGES-2:0], sck_i};
      si_sh  <= {si_sh[STAGES-2:0], si_i};
      sck_d  <= sck_s;
      sel_d  <= sel;
    end
  end

  assign rst_sync_n = rst_sh[1];
  assign sel        = ~cs_sh[STAGES-1];
  assign sck_s      = sck_sh[STAGES-1];
  assign si_s       = si_sh[STAGES-1];
  assign sck_rise   = sck_s & ~sck_d;
  assign sck_fall   = ~sck_s & sck_d;
  assign cs_done    = sel_d & ~sel;
endmodule

// File: rtl/spif_cmd.sv
module spif_cmd
  import spif_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_done,
  input  logic          si,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    status,
  output logic [AW-1:0] rd_idx,
  output logic [AW-1:0] prog_idx,
  output logic [7:0]    prog_data,
  output logic          prog_go,
  output logic          wren_go,
  output logic          so,
  output logic          so_oe
);
  phase_e phase_q, phase_n;
  kind_e  kind_q, kind_n;
  logic [2:0]  bcnt_q, bcnt_n, fcnt_q, fcnt_n;
  logic [1:0]  acnt_q, acnt_n;
  logic [6:0]  rx_q, rx_n;
  logic [23:0] addr_q, addr_n;
  logic [7:0]  wdata_q, wdata_n, tx_q, tx_n, rx_byte, cur;
  logic        so_q, so_n;

  assign rx_byte = {rx_q, si};
  assign cur     = (kind_q == CMD_STAT) ? status : rd_data;

  always_comb begin
    phase_n = phase_q;  kind_n  = kind_q;  bcnt_n = bcnt_q;
    fcnt_n  = fcnt_q;   acnt_n  = acnt_q;  rx_n   = rx_q;
    addr_n  = addr_q;   wdata_n = wdata_q; tx_n   = tx_q;
    so_n    = so_q;
    if (!sel) begin
      phase_n = PH_OPC;
      kind_n  = CMD_NONE;
      bcnt_n  = '0;
      fcnt_n  = '0;
      acnt_n  = '0;
    end else begin
      if (sck_rise) begin
        rx_n   = rx_byte[6:0];
        bcnt_n = bcnt_q + 3'd1;
        if (bcnt_q == 3'd7) begin
          unique case (phase_q)
            PH_OPC: begin
              unique case (rx_byte)
                OPC_READ: begin kind_n = CMD_READ; phase_n = PH_ADDR;   end
                OPC_PROG: begin kind_n = CMD_PROG; phase_n = PH_ADDR;   end
                OPC_WREN: begin kind_n = CMD_WREN; phase_n = PH_DONE;   end
                OPC_STAT: begin kind_n = CMD_STAT; phase_n = PH_STREAM; end
                default:  phase_n = PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              addr_n = {addr_q[15:0], rx_byte};
              acnt_n = acnt_q + 2'd1;
              if (acnt_q == 2'd2)
                phase_n = (kind_q == CMD_READ) ? PH_DUMMY : PH_WDATA;
            end
            PH_DUMMY: phase_n = PH_STREAM;
            PH_WDATA: begin wdata_n = rx_byte; phase_n = PH_DONE; end
            default: ;
          endcase
        end
      end
      if (sck_fall && phase_q == PH_STREAM) begin
        fcnt_n = fcnt_q + 3'd1;
        if (fcnt_q == 3'd0) begin
          so_n = cur[7];
          tx_n = {cur[6:0], 1'b0};
          if (kind_q == CMD_READ) addr_n = addr_q + 24'd1;
        end else begin
          so_n = tx_q[7];
          tx_n = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;  kind_q  <= CMD_NONE; bcnt_q <= '0;
      fcnt_q  <= '0;      acnt_q  <= '0;       rx_q   <= '0;
      addr_q  <= '0;      wdata_q <= '0;       tx_q   <= '0;
      so_q    <= 1'b0;
    end else begin
      phase_q <= phase_n; kind_q  <= kind_n;   bcnt_q <= bcnt_n;
      fcnt_q  <= fcnt_n;  acnt_q  <= acnt_n;   rx_q   <= rx_n;
      addr_q  <= addr_n;  wdata_q <= wdata_n;  tx_q   <= tx_n;
      so_q    <= so_n;
    end
  end

  assign rd_idx    = addr_q[AW-1:0];
  assign prog_idx  = addr_q[AW-1:0];
  assign prog_data = wdata_q;
  assign prog_go   = cs_done && phase_q == PH_DONE && kind_q == CMD_PROG && bcnt_q == 3'd0;
  assign wren_go   = cs_done && phase_q == PH_DONE && kind_q == CMD_WREN && bcnt_q == 3'd0;
  assign so        = so_q;
  assign so_oe     = sel && phase_q == PH_STREAM;
endmodule

// File: rtl/spif_array.sv
module spif_array #(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned AW          = 8,
  parameter int unsigned PROT_LO     = 240,
  parameter int unsigned PROT_HI     = 255,
  parameter int unsigned PROG_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_go,
  input  logic          wren_go,
  input  logic [AW-1:0] prog_idx,
  input  logic [7:0]    prog_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [7:0]    status,
  output logic          busy,
  output logic          wel
);
  localparam int unsigned TW = $clog2(PROG_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [TW-1:0] tmr_q, tmr_n;
  logic          busy_q, busy_n, wel_q, wel_n, in_prot, accept;

  assign in_prot = (32'(prog_idx) >= PROT_LO) && (32'(prog_idx) <= PROT_HI);
  assign accept  = prog_go && wel_q && !busy_q && !in_prot;

  always_comb begin
    busy_n = busy_q;
    wel_n  = wel_q;
    tmr_n  = tmr_q;
    if (busy_q) begin
      if (tmr_q == '0) begin
        busy_n = 1'b0;
        wel_n  = 1'b0;
      end else begin
        tmr_n = tmr_q - 1'b1;
      end
    end else begin
      if (wren_go) wel_n = 1'b1;
      if (accept) begin
        busy_n = 1'b1;
        tmr_n  = TW'(PROG_CYCLES - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      busy_q <= busy_n;
      wel_q  <= wel_n;
      tmr_q  <= tmr_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic word_we;
    assign word_we = accept && (prog_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[g] <= 8'hFF;
      else if (word_we) mem[g] <= mem[g] & prog_data;
    end
  end

  assign rd_data = mem[rd_idx];
  assign status  = {6'b0, wel_q, busy_q};
  assign busy    = busy_q;
  assign wel     = wel_q;
endmodule

// File: rtl/spif_engine.sv
module spif_engine #(
  parameter int unsigned MEM_DEPTH   = 256,
  parameter int unsigned PROT_LO     = 240,
  parameter int unsigned PROT_HI     = 255,
  parameter int unsigned PROG_CYCLES = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int unsigned AW = $clog2(MEM_DEPTH);

  logic          rst_sync_n, sel, sck_rise, sck_fall, cs_done, si_s;
  logic          prog_go, wren_go, busy, wel;
  logic [AW-1:0] rd_idx, prog_idx;
  logic [7:0]    prog_data, rd_data, status;

  spif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
    .rst_sync_n(rst_sync_n), .sel(sel), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_done(cs_done), .si_s(si_s)
  );

  spif_cmd #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .sel(sel), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_done(cs_done), .si(si_s),
    .rd_data(rd_data), .status(status), .rd_idx(rd_idx),
    .prog_idx(prog_idx), .prog_data(prog_data), .prog_go(prog_go),
    .wren_go(wren_go), .so(so), .so_oe(so_oe)
  );

  spif_array #(
    .DEPTH(MEM_DEPTH), .AW(AW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_array (
    .clk(clk), .rst_n(rst_sync_n), .prog_go(prog_go), .wren_go(wren_go),
    .prog_idx(prog_idx), .prog_data(prog_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .status(status), .busy(busy), .wel(wel)
  );
endmodule

// File: rtl/spif_engine_chk.sv
module spif_engine_chk #(
  parameter int unsigned AW          = 8,
  parameter int unsigned PROT_LO     = 240,
  parameter int unsigned PROT_HI     = 255,
  parameter int unsigned PROG_CYCLES = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wel,
  input logic          prog_go,
  input logic          sck_rise,
  input logic          so_oe,
  input logic [AW-1:0] prog_idx
);
  logic [31:0] busy_cnt;
  logic        in_prot;

  assign in_prot = (32'(prog_idx) >= PROT_LO) && (32'(prog_idx) <= PROT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 32'd1;
    else           busy_cnt <= '0;
  end

  p_busy_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  p_busy_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go));
  p_prot_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(in_prot));
  p_wel_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == PROG_CYCLES));
  p_oe_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_rise));
endmodule

bind spif_engine spif_engine_chk #(
  .AW(AW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .prog_go(prog_go),
  .sck_rise(sck_rise), .so_oe(so_oe), .prog_idx(prog_idx)
);

// File: tb/spif_engine_tb.sv
module spif_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int PROG       = 400;

  logic clk, rst_n, cs_n, sck, si, so, so_oe;
  logic oe_smp, cur_m3, done;
  int   n_chk, n_fail;

  spif_engine #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(input logic m3);
    cur_m3 = m3;
    sck = m3;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic stop();
    sck = cur_m3;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si  = tx[7-i];
      repeat (H) @(negedge clk);
      rx     = {rx[6:0], so};
      oe_smp = so_oe;
      sck    = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic wren_cmd();
    logic [7:0] r;
    start(1'b0); xfer(8'h06, 8, r); stop();
  endtask

  task automatic prog_cmd(input logic [23:0] a, input logic [7:0] d);
    logic [7:0] r;
    start(1'b0);
    xfer(8'h02, 8, r); xfer(a[23:16], 8, r); xfer(a[15:8], 8, r);
    xfer(a[7:0], 8, r); xfer(d, 8, r);
    stop();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] r;
    start(1'b0); xfer(8'h05, 8, r); xfer(8'h00, 8, s); stop();
  endtask

  task automatic read_bytes(input logic [23:0] a, input logic [7:0] dmy, input int n,
                            input logic m3, output logic [31:0] d,
                            output logic oe_cmd, output logic oe_dat);
    logic [7:0] r;
    d = '0;
    start(m3);
    xfer(8'h0B, 8, r);     oe_cmd = oe_smp;
    xfer(a[23:16], 8, r);  oe_cmd = oe_cmd | oe_smp;
    xfer(a[15:8], 8, r);   oe_cmd = oe_cmd | oe_smp;
    xfer(a[7:0], 8, r);    oe_cmd = oe_cmd | oe_smp;
    xfer(dmy, 8, r);       oe_cmd = oe_cmd | oe_smp;
    oe_dat = 1'b1;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r);
      oe_dat = oe_dat & oe_smp;
      d = {d[23:0], r};
    end
    stop();
  endtask

  task automatic t_reset();
    logic [7:0] s; logic [31:0] d; logic oc, od;
    check("R9 so_oe idle after reset", 32'(so_oe), 32'd0);
    read_status(s);
    check("R14 status after reset", 32'(s), 32'h00);
    read_bytes(24'h000020, 8'h00, 1, 1'b0, d, oc, od);
    check("R14 erased byte after reset", d, 32'hFF);
  endtask

  task automatic t_prog_no_wel();
    logic [31:0] d; logic oc, od;
    prog_cmd(24'h000010, 8'h00);
    repeat (PROG + 50) @(negedge clk);
    read_bytes(24'h000010, 8'h00, 1, 1'b0, d, oc, od);
    check("R5 program without latch ignored", d, 32'hFF);
  endtask

  task automatic t_wren_abort();
    logic [7:0] r, s;
    start(1'b0); xfer(8'h06, 8, r); xfer(8'hFF, 3, r); stop();
    read_status(s);
    check("R12 partial byte aborts write-enable", 32'(s), 32'h00);
    wren_cmd();
    read_status(s);
    check("R11 write-enable sets latch bit1", 32'(s), 32'h02);
  endtask

  task automatic t_program();
    logic [7:0] s; logic [31:0] d; logic oc, od;
    prog_cmd(24'h000010, 8'hA5);
    read_status(s);
    check("R6 busy bit0 during program", 32'(s), 32'h03);
    repeat (PROG + 50) @(negedge clk);
    read_status(s);
    check("R11 latch and busy clear after program", 32'(s), 32'h00);
    read_bytes(24'h000010, 8'h00, 1, 1'b0, d, oc, od);
    check("R4 programmed byte", d, 32'hA5);
  endtask

  task automatic t_and();
    logic [31:0] d; logic oc, od;
    wren_cmd();
    prog_cmd(24'h000010, 8'h3C);
    repeat (PROG + 50) @(negedge clk);
    read_bytes(24'h000010, 8'h00, 1, 1'b0, d, oc, od);
    check("R7 program ANDs old and new", d, 32'h24);
  endtask

  task automatic t_protect();
    logic [7:0] s; logic [31:0] d; logic oc, od;
    wren_cmd();
    prog_cmd(24'h0000F4, 8'h00);
    read_status(s);
    check("R8 protected program: no busy, latch kept", 32'(s), 32'h02);
    read_bytes(24'h0000F4, 8'h00, 1, 1'b0, d, oc, od);
    check("R8 protected byte unchanged", d, 32'hFF);
  endtask

  task automatic t_prog_abort();
    logic [7:0] r, s; logic [31:0] d; logic oc, od;
    start(1'b0);
    xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h00, 8, r);
    xfer(8'h20, 8, r); xfer(8'h00, 8, r); xfer(8'h00, 3, r);
    stop();
    read_status(s);
    check("R12 aborted program: no busy", 32'(s), 32'h02);
    read_bytes(24'h000020, 8'h00, 1, 1'b0, d, oc, od);
    check("R12 aborted program leaves byte", d, 32'hFF);
  endtask

  task automatic t_stream_wrap();
    logic [31:0] d; logic oc, od;
    prog_cmd(24'h000000, 8'h5A);
    repeat (PROG + 50) @(negedge clk);
    wren_cmd();
    prog_cmd(24'h000001, 8'h11);
    repeat (PROG + 50) @(negedge clk);
    read_bytes(24'h3A00FE, 8'h00, 4, 1'b0, d, oc, od);
    check("R3 wrap from top index to 0, high bits ignored", d, 32'hFFFF5A11);
    check("R2 four consecutive bytes streamed", d[15:0], 32'h5A11);
    check("R9 so_oe low in command bytes", 32'(oc), 32'd0);
    check("R9 so_oe high in data bytes", 32'(od), 32'd1);
  endtask

  task automatic t_modes();
    logic [31:0] d0, d3; logic oc, od;
    read_bytes(24'h000010, 8'h00, 2, 1'b0, d0, oc, od);
    check("R1 read mode 0 dummy 00", d0, 32'h24FF);
    read_bytes(24'h000010, 8'hFF, 2, 1'b1, d3, oc, od);
    check("R13 read mode 3 dummy FF", d3, 32'h24FF);
    check("R1 dummy value has no effect", d3, d0);
  endtask

  task automatic t_status_stream();
    logic [7:0] r, s0, s1;
    wren_cmd();
    start(1'b1);
    xfer(8'h05, 8, r); xfer(8'h00, 8, s0); xfer(8'h00, 8, s1);
    stop();
    check("R10 status first byte", 32'(s0), 32'h02);
    check("R10 status repeats", 32'(s1), 32'h02);
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_fail = 0;
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; oe_smp = 1'b0; cur_m3 = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_prog_no_wel();
    t_wren_abort();
    t_program();
    t_and();
    t_protect();
    t_prog_abort();
    t_stream_wrap();
    t_modes();
    t_status_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule